// File: doc/BRIEF.md
# Predicated Three-Way Interleaving Store Unit

This block writes three vectors of 16-bit elements to memory in interleaved form. For every element position `g` it forms a six-byte group made of element `g` of vector 0, then vector 1, then vector 2. Each group follows the previous one with no gap. The first group starts at `base + (idx << 1)`, so the index counts halfwords. One mask bit for each position decides whether that position's whole group is written. A cleared bit suppresses all six bytes of its group, and the block never presents those bytes to memory. This means a masked group cannot raise a memory error.

A one-cycle `start` pulse captures all operands. The block then walks the destination range in 8-byte-aligned beats and drives a 64-bit write port with byte strobes and a valid/ready handshake. An unaligned start address is handled only through the strobes. A beat with no active byte is skipped. When the last beat has been accepted, or when the port reports an error, the block pulses `done`. After an error it also raises `fault` and reports the address of the failing beat.

Top module: `ilv3_store`

## Requirements
- R1: The first group begins at byte address `base + 2*idx`, with 64-bit wraparound. Every issued beat has `wr_addr[2:0] == 0`.
- R2: Memory is little-endian. Group `g` occupies bytes `6g..6g+5` from the start address. Those bytes hold, in order: the low byte and high byte of vector 0 element `g`, then the same two bytes of vector 1 element `g`, then the same two bytes of vector 2 element `g`. Element `g` is bits `[16g+15:16g]` of its vector. Lane `j` of `wr_data` is bits `[8j+7:8j]` and goes to address `wr_addr + j`.
- R3: `wr_strb[j]` is 1 only when byte `wr_addr + j` belongs to a group whose `pmask` bit is 1. Bytes of masked groups are never strobed.
- R4: The block never raises `wr_valid` for a beat whose strobes would all be zero. Beats are issued in ascending address order.
- R5: When `pmask` is all zero, `done` is pulsed and no beat is issued.
- R6: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `wr_strb` hold their values.
- R7: If a beat is accepted while `wr_err` is high, no further beat is issued. On the following cycle `done` and `fault` are 1 and `fault_addr` holds that beat's address.
- R8: `done` is a single-cycle pulse. It follows the cycle in which the last beat was accepted or the last empty beat was passed. `busy` is high from the cycle after `start` until `done`. A `start` pulse while `busy` is high is ignored.
- R9: An operation that completes without an error response ends with `fault` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when idle |
| vec0 | input | VLEN | First source vector |
| vec1 | input | VLEN | Second source vector |
| vec2 | input | VLEN | Third source vector |
| pmask | input | VLEN/16 | Per-position group enable |
| base | input | AW | Base byte address |
| idx | input | AW | Halfword index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | End-of-operation pulse |
| fault | output | 1 | Last operation ended on an error response |
| fault_addr | output | AW | Address of the failing beat |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_err | input | 1 | Error response for the accepted beat |
| wr_addr | output | AW | 8-byte-aligned beat address |
| wr_data | output | 64 | Beat data |
| wr_strb | output | 8 | Byte enables |

## Verification
The assertions check several properties on every cycle:
- beat alignment;
- that address, data and strobes are held during a stall;
- that `done` lasts one cycle and only ends a busy period;
- that an error response ends the operation on the next cycle with the fault flag set.

Some behaviours can only be shown by the bench's scenarios, which compare each beat against a byte-level memory model: the exact interleaving order, the byte placement for unaligned starts, the strobe gating of masked groups, the skipping of empty beats, silence on an all-zero mask, and the suppression of a second start.

// File: rtl/ilv3_store.sv
module ilv3_store #(
  parameter int VLEN = 128,
  parameter int AW   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VLEN-1:0]   vec0,
  input  logic [VLEN-1:0]   vec1,
  input  logic [VLEN-1:0]   vec2,
  input  logic [VLEN/16-1:0] pmask,
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     idx,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [AW-1:0]     fault_addr,
  output logic              wr_valid,
  input  logic              wr_ready,
  input  logic              wr_err,
  output logic [AW-1:0]     wr_addr,
  output logic [63:0]       wr_data,
  output logic [7:0]        wr_strb
);
  localparam int NEL    = VLEN / 16;
  localparam int NBYTES = 6 * NEL;
  localparam int MAXB   = (NBYTES + 7) / 8 + 1;
  localparam int BW     = $clog2(MAXB + 1);

  logic [VLEN-1:0] v0, v1, v2;
  logic [NEL-1:0]  pm;
  logic [AW-1:0]   saddr;
  logic [BW-1:0]   beat, last;

  logic [AW-1:0] s_new;
  logic [2:0]    off;
  logic [AW-1:0] aligned;
  logic          step, hit_err, at_last;

  assign s_new   = base + (idx << 1);
  assign off     = saddr[2:0];
  assign aligned = {saddr[AW-1:3], 3'b000};
  assign wr_addr = aligned + (AW'(beat) << 3);

  always_comb begin
    int pos, rel, g, w;
    wr_data = '0;
    wr_strb = '0;
    for (int j = 0; j < 8; j++) begin
      pos = int'(beat) * 8 + j;
      rel = pos - int'(off);
      if (rel >= 0 && rel < NBYTES) begin
        g = rel / 6;
        w = rel % 6;
        case (w / 2)
          0:       wr_data[j*8 +: 8] = v0[g*16 + (w%2)*8 +: 8];
          1:       wr_data[j*8 +: 8] = v1[g*16 + (w%2)*8 +: 8];
          default: wr_data[j*8 +: 8] = v2[g*16 + (w%2)*8 +: 8];
        endcase
        wr_strb[j] = pm[g];
      end
    end
  end

  assign wr_valid = busy && (wr_strb != 8'h00);
  assign step     = busy && (!wr_valid || wr_ready);
  assign hit_err  = wr_valid && wr_ready && wr_err;
  assign at_last  = (beat == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_addr <= '0;
      beat       <= '0;
      last       <= '0;
      saddr      <= '0;
      pm         <= '0;
      v0         <= '0;
      v1         <= '0;
      v2         <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          fault <= 1'b0;
          beat  <= '0;
          last  <= BW'((int'(s_new[2:0]) + NBYTES - 1) >> 3);
          saddr <= s_new;
          pm    <= pmask;
          v0    <= vec0;
          v1    <= vec1;
          v2    <= vec2;
        end
      end else if (step) begin
        if (hit_err) begin
          busy       <= 1'b0;
          done       <= 1'b1;
          fault      <= 1'b1;
          fault_addr <= wr_addr;
        end else if (at_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          beat <= beat + 1'b1;
        end
      end
    end
  end

  AST_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[2:0] == 3'b000); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_strb)); // R6

  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && wr_err |=> done && fault && !busy && !wr_valid); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy) && !busy); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid); // R4
endmodule

// File: tb/test_ilv3_store.sv
module test_ilv3_store;
  localparam int VLEN = 128;
  localparam int NEL  = VLEN / 16;
  localparam int NB   = 6 * NEL;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start, busy, done, fault, wr_valid, wr_ready, wr_err;
  logic [VLEN-1:0] vec0, vec1, vec2;
  logic [NEL-1:0]  pmask;
  logic [63:0]     base, idx, fault_addr, wr_addr, wr_data;
  logic [7:0]      wr_strb;

  ilv3_store #(.VLEN(VLEN), .AW(64)) i_ilv3_store (
    .clk(clk), .rst_n(rst_n), .start(start), .vec0(vec0), .vec1(vec1), .vec2(vec2),
    .pmask(pmask), .base(base), .idx(idx), .busy(busy), .done(done), .fault(fault),
    .fault_addr(fault_addr), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_err(wr_err),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb));

  int n_checks = 0, n_fail = 0;
  logic [63:0] q_addr[$];
  logic [63:0] q_data[$];
  logic [7:0]  q_strb[$];
  int  err_beat = -1, beat_no = 0, stall_pct = 0;
  bit  exp_fault = 0;
  logic [63:0] exp_faddr = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ebyte(input logic [VLEN-1:0] a0, a1, a2, input int g, input int w);
    logic [VLEN-1:0] v;
    v = (w < 2) ? a0 : (w < 4) ? a1 : a2;
    return v[g*16 + (w%2)*8 +: 8];
  endfunction

  function automatic logic [63:0] smask(input logic [7:0] s);
    logic [63:0] m;
    for (int j = 0; j < 8; j++) m[j*8 +: 8] = {8{s[j]}};
    return m;
  endfunction

  task automatic model(input logic [63:0] b, ix, input logic [NEL-1:0] pm,
                       input logic [VLEN-1:0] a0, a1, a2);
    logic [63:0] s, lo;
    logic [7:0]  mv[0:NB+15];
    bit          ms[0:NB+15];
    int o, nbt;
    s  = b + (ix << 1);
    lo = {s[63:3], 3'b000};
    o  = int'(s[2:0]);
    for (int k = 0; k < NB + 16; k++) begin mv[k] = '0; ms[k] = 0; end
    for (int g = 0; g < NEL; g++)
      if (pm[g])
        for (int w = 0; w < 6; w++) begin
          mv[o + 6*g + w] = ebyte(a0, a1, a2, g, w);
          ms[o + 6*g + w] = 1;
        end
    nbt = (o + NB + 7) / 8;
    for (int bt = 0; bt < nbt; bt++) begin
      logic [7:0]  st;
      logic [63:0] dt;
      st = '0; dt = '0;
      for (int j = 0; j < 8; j++) begin
        st[j] = ms[bt*8 + j];
        dt[j*8 +: 8] = mv[bt*8 + j];
      end
      if (st != 0) begin
        q_addr.push_back(lo + 64'(bt) * 8);
        q_data.push_back(dt);
        q_strb.push_back(st);
      end
    end
  endtask

  always @(negedge clk) begin
    bit rdy;
    if (rst_n) begin
      if (wr_valid) begin
        if (q_addr.size() == 0)
          check(0, "R4/R7", "beat with none expected", wr_addr, 64'h0);
        else begin
          check(wr_addr == q_addr[0], "R1", "beat address", wr_addr, q_addr[0]);
          check((wr_data & smask(q_strb[0])) == q_data[0], "R2", "beat data", wr_data & smask(q_strb[0]), q_data[0]);
          check(wr_strb == q_strb[0], "R3", "beat strobes", {56'h0, wr_strb}, {56'h0, q_strb[0]});
        end
      end
      rdy = ($urandom_range(99) >= stall_pct);
      wr_ready = rdy;
      wr_err   = 1'b0;
      if (wr_valid && rdy && q_addr.size() != 0) begin
        if (beat_no == err_beat) begin
          wr_err    = 1'b1;
          exp_fault = 1;
          exp_faddr = q_addr[0];
          q_addr.delete(); q_data.delete(); q_strb.delete();
        end else begin
          void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_strb.pop_front());
        end
        beat_no++;
      end
    end
  end

  task automatic run_op(input logic [63:0] b, ix, input logic [NEL-1:0] pm,
                        input logic [VLEN-1:0] a0, a1, a2,
                        input int errb, input int stall, input bit poke);
    int cyc;
    model(b, ix, pm, a0, a1, a2);
    err_beat = errb; beat_no = 0; stall_pct = stall; exp_fault = 0;
    @(negedge clk);
    base = b; idx = ix; pmask = pm; vec0 = a0; vec1 = a1; vec2 = a2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8", "busy after start", {63'h0, busy}, 64'h1);
    if (poke) begin
      pmask = ~pm; vec0 = ~a0; base = b + 64'h40; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
    if (!done) begin
      check(0, "R8", "watchdog waiting for done", 64'h0, 64'h1);
      return;
    end
    check(q_addr.size() == 0, "R8", "beats left at done", 64'(q_addr.size()), 64'h0);
    check(fault == exp_fault, exp_fault ? "R7" : "R9", "fault flag", {63'h0, fault}, {63'h0, exp_fault});
    if (exp_fault) check(fault_addr == exp_faddr, "R7", "fault address", fault_addr, exp_faddr);
    if (pm == 0) check(beat_no == 0, "R5", "beats for empty mask", 64'(beat_no), 64'h0);
    @(negedge clk);
    check(done == 1'b0, "R8", "done one cycle", {63'h0, done}, 64'h0);
    check(busy == 1'b0, "R8", "idle after done", {63'h0, busy}, 64'h0);
    check(!wr_valid, "R7", "no beat after end", {63'h0, wr_valid}, 64'h0);
  endtask

  function automatic logic [VLEN-1:0] pat(input logic [15:0] tag);
    logic [VLEN-1:0] v;
    for (int g = 0; g < NEL; g++) v[g*16 +: 16] = tag + 16'(g) * 16'h0101;
    return v;
  endfunction

  initial begin
    #1_200_000;
    check(0, "R8", "global watchdog", 64'h0, 64'h1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; wr_ready = 1'b0; wr_err = 1'b0;
    vec0 = '0; vec1 = '0; vec2 = '0; pmask = '0; base = '0; idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0, "R8", "reset state busy/done", {62'h0, busy, done}, 64'h0);
    check(wr_valid == 0, "R4", "reset state valid", {63'h0, wr_valid}, 64'h0);

    // R1 R2 R3: aligned, full mask
    run_op(64'h1000, 64'h0, '1, pat(16'h1100), pat(16'h2200), pat(16'h3300), -1, 0, 0);
    // R1 R2: unaligned start via odd index, stalls (R6)
    run_op(64'h2003, 64'h3, 8'b1011_0110, pat(16'hA000), pat(16'hB000), pat(16'hC000), -1, 40, 0);
    // R3 R4: single group, empty beats skipped
    run_op(64'h3000, 64'h1, 8'b0001_0000, pat(16'h5500), pat(16'h6600), pat(16'h7700), -1, 20, 0);
    // R5: empty mask
    run_op(64'h4000, 64'h5, 8'h00, pat(16'h0101), pat(16'h0202), pat(16'h0303), -1, 0, 0);
    // R3: masked groups at a wrapping address
    run_op(64'hFFFF_FFFF_FFFF_FFF0, 64'h2, 8'b1000_0001, pat(16'h1234), pat(16'h5678), pat(16'h9ABC), -1, 30, 0);
    // R7: error on the third beat
    run_op(64'h5000, 64'h0, '1, pat(16'h4400), pat(16'h4500), pat(16'h4600), 2, 25, 0);
    // R9: a clean run after a faulting one clears the flag
    run_op(64'h5800, 64'h7, 8'b0110_0011, pat(16'h0A0A), pat(16'h0B0B), pat(16'h0C0C), -1, 10, 0);
    // R8: start while busy is ignored
    run_op(64'h6006, 64'h1, 8'b1111_0000, pat(16'hD100), pat(16'hD200), pat(16'hD300), -1, 50, 1);
    // R7: error on the first beat
    run_op(64'h7001, 64'h0, 8'b0000_0001, pat(16'hE100), pat(16'hE200), pat(16'hE300), 0, 0, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule